// File: doc/BRIEF.md
# Serial Block-Transform Command Controller

This controller turns a host byte stream into the work sequence of a block-transform accelerator. A session opens with an 8-byte header. The first byte selects the direction of the transform. The next two bytes carry the number of blocks, most significant byte first. The last five bytes are padding and are discarded. A 64-byte scaling table follows the header and is forwarded once per session. After that the controller loops once per block:

1. It gathers 64 sample bytes in row-major order.
2. It pulses the compute core to start.
3. It waits for the core to signal completion.
4. It replies with the ASCII key "done".
5. It sends the 64 16-bit results, each one high byte first.

Received bytes arrive through a valid/ready pair, and transmitted bytes leave through another valid/ready pair. Table and sample bytes share one registered write port, and a select bit tells the two apart. Results come back through an address/data read port that has one cycle of latency, as a synchronous block RAM has. Receive is closed while the controller waits on the core and while it transmits. Any byte the host offers during that time stays with the host until the next receive phase.

Top module: `xform_cmd_ctrl`

## Requirements
- R1: A session starts with exactly 8 accepted header bytes. Bit 0 of header byte 0 sets `core_inverse`: 1 means the inverse transform and 0 means the forward transform. The value is held for the whole session.
- R2: The block count is header byte 1 (upper 8 bits) concatenated with header byte 2 (lower 8 bits). The values of header bytes 3 to 7 have no effect on any output.
- R3: The 64 bytes after the header go out on the write port with `wr_table`=1 and `wr_addr` running 0 to 63 in arrival order. Each write appears in the cycle after its byte was accepted.
- R4: Each block's 64 sample bytes are written with `wr_table`=0 and addresses 0 to 63. `core_start` is a one-cycle pulse, and it comes only after all 64 samples of the block have been written.
- R5: After `core_done`, the first four bytes sent are 0x64, 0x6F, 0x6E, 0x65 ("done").
- R6: Next, results 0 to 63 are read at `res_addr` 0 to 63 and sent as bits 15:8, then bits 7:0, giving 128 bytes per block.
- R7: The block sequence runs exactly the requested number of times. The controller then accepts a new header.
- R8: `busy` rises when the table ends with a nonzero count. It falls when the last result byte of the last block is taken. `core_start` and `tx_valid` occur only while `busy` is high.
- R9: A block count of zero produces no start pulse and no transmitted byte. The controller goes straight back to header reception.
- R10: `rx_ready` is low from `core_start` until the last result byte of the block has been sent.
- R11: Once `tx_valid` is high, `tx_valid` and `tx_data` hold unchanged until `tx_ready` takes the byte.
- R12: Synchronous `rst` returns the controller to header reception. It clears all byte counters, `busy` and `tx_valid`, so a session cut short leaves no residue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Controller accepts the received byte |
| tx_valid | output | 1 | Outgoing byte present |
| tx_data | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Transmitter takes the outgoing byte |
| core_start | output | 1 | One-cycle start pulse to the compute core |
| core_inverse | output | 1 | Direction of the transform for the session |
| core_done | input | 1 | Compute core completion pulse |
| wr_en | output | 1 | Write strobe for table or sample store |
| wr_table | output | 1 | 1 selects the table store, 0 selects the sample store |
| wr_addr | output | 6 | Write address |
| wr_data | output | 8 | Write data |
| res_addr | output | 6 | Result read address |
| res_data | input | 16 | Result read data, valid one cycle after the address |
| busy | output | 1 | Blocks in progress |

## Verification
The hardest situation to reach is the host pushing the next block's samples while the current block is still being answered. Here the receive side must stay closed and the transmitter stalls at random points. The stimulus reaches this by sending the next byte without waiting for replies and by throttling `tx_ready` at random, while the core model signals completion after a random delay. Two more cases are checked. A reset in the middle of the table tests that no counter keeps its position. A zero block count tests that no block sequence runs at all.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
  typedef enum logic [3:0] {
    ST_HDR, ST_TAB, ST_SAMP, ST_WAIT, ST_KEY, ST_FETCH, ST_LOAD, ST_HI, ST_LO
  } xfc_state_e;

  localparam int KEY_LEN = 4;

  // completion key characters, in transmit order
  function automatic logic [7:0] key_char(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h64;
      2'd1:    return 8'h6F;
      2'd2:    return 8'h6E;
      default: return 8'h65;
    endcase
  endfunction
endpackage

// File: rtl/xfc_hdr_regs.sv
module xfc_hdr_regs #(
  parameter int HDR_BYTES = 8,
  parameter int CNT_W     = 16,
  localparam int IDX_W    = $clog2(HDR_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       byte_in,
  output logic             inverse,
  output logic [CNT_W-1:0] blk_count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      inverse   <= 1'b0;
      blk_count <= '0;
    end else if (take) begin
      if (idx == IDX_W'(0)) inverse <= byte_in[0];
      if (idx == IDX_W'(1)) blk_count[CNT_W-1 -: 8] <= byte_in;
      if (idx == IDX_W'(2)) blk_count[7:0] <= byte_in;
    end
  end
endmodule

// File: rtl/xfc_wr_port.sv
module xfc_wr_port #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              is_table,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output logic              wr_en,
  output logic              wr_table,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en    <= 1'b0;
      wr_table <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= take;
      if (take) begin
        wr_table <= is_table;
        wr_addr  <= addr;
        wr_data  <= data;
      end
    end
  end
endmodule

// File: rtl/xfc_tx_stage.sv
module xfc_tx_stage (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       clear,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       fire
);
  assign fire = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (load) begin
      tx_valid <= 1'b1;
      tx_data  <= load_byte;
    end else if (clear) begin
      tx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xform_cmd_ctrl.sv
module xform_cmd_ctrl
  import xfc_pkg::*;
#(
  parameter int SAMPLES   = 64,
  parameter int HDR_BYTES = 8,
  parameter int RES_W     = 16,
  localparam int ADDR_W   = $clog2(SAMPLES),
  localparam int HIDX_W   = $clog2(HDR_BYTES),
  localparam int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              core_start,
  output logic              core_inverse,
  input  logic              core_done,
  output logic              wr_en,
  output logic              wr_table,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic [ADDR_W-1:0] res_addr,
  input  logic [RES_W-1:0]  res_data,
  output logic              busy
);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(SAMPLES - 1);
  localparam logic [HIDX_W-1:0] LAST_HDR = HIDX_W'(HDR_BYTES - 1);
  localparam logic [1:0]        LAST_KEY = 2'(KEY_LEN - 1);

  xfc_state_e        state;
  logic [HIDX_W-1:0] hdr_idx;
  logic [ADDR_W-1:0] cnt;
  logic [1:0]        key_idx;
  logic [CNT_W-1:0]  blk_left;
  logic [CNT_W-1:0]  blk_count;
  logic [7:0]        lo_hold;
  logic              take, fire;
  logic              tx_load, tx_clear;
  logic [7:0]        tx_byte;

  assign rx_ready = (state == ST_HDR) || (state == ST_TAB) || (state == ST_SAMP);
  assign take     = rx_valid && rx_ready;

  xfc_hdr_regs #(.HDR_BYTES(HDR_BYTES), .CNT_W(CNT_W)) u_hdr (
    .clk(clk), .rst(rst), .take(take && state == ST_HDR), .idx(hdr_idx),
    .byte_in(rx_data), .inverse(core_inverse), .blk_count(blk_count)
  );

  xfc_wr_port #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst(rst), .take(take && state != ST_HDR),
    .is_table(state == ST_TAB), .addr(cnt), .data(rx_data),
    .wr_en(wr_en), .wr_table(wr_table), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // byte source selection for the transmit stage
  always_comb begin
    tx_load  = 1'b0;
    tx_clear = 1'b0;
    tx_byte  = 8'h00;
    case (state)
      ST_WAIT: if (core_done) begin
        tx_load = 1'b1;
        tx_byte = key_char(2'd0);
      end
      ST_KEY: if (fire) begin
        if (key_idx == LAST_KEY) tx_clear = 1'b1;
        else begin
          tx_load = 1'b1;
          tx_byte = key_char(key_idx + 2'd1);
        end
      end
      ST_LOAD: begin
        tx_load = 1'b1;
        tx_byte = res_data[15:8];
      end
      ST_HI: if (fire) begin
        tx_load = 1'b1;
        tx_byte = lo_hold;
      end
      ST_LO: if (fire) tx_clear = 1'b1;
      default: ;
    endcase
  end

  xfc_tx_stage u_tx (
    .clk(clk), .rst(rst), .load(tx_load), .load_byte(tx_byte), .clear(tx_clear),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .fire(fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_HDR;
      hdr_idx    <= '0;
      cnt        <= '0;
      key_idx    <= '0;
      blk_left   <= '0;
      lo_hold    <= '0;
      busy       <= 1'b0;
      core_start <= 1'b0;
      res_addr   <= '0;
    end else begin
      core_start <= 1'b0;
      case (state)
        ST_HDR: if (take) begin
          if (hdr_idx == LAST_HDR) begin
            hdr_idx <= '0;
            state   <= ST_TAB;
          end else begin
            hdr_idx <= hdr_idx + HIDX_W'(1);
          end
        end
        ST_TAB: if (take) begin
          cnt <= cnt + ADDR_W'(1);
          if (cnt == LAST_IDX) begin
            if (blk_count == '0) begin
              state <= ST_HDR;
            end else begin
              busy     <= 1'b1;
              blk_left <= blk_count;
              state    <= ST_SAMP;
            end
          end
        end
        ST_SAMP: if (take) begin
          cnt <= cnt + ADDR_W'(1);
          if (cnt == LAST_IDX) begin
            core_start <= 1'b1;
            state      <= ST_WAIT;
          end
        end
        ST_WAIT: if (core_done) begin
          key_idx <= '0;
          state   <= ST_KEY;
        end
        ST_KEY: if (fire) begin
          if (key_idx == LAST_KEY) begin
            res_addr <= '0;
            state    <= ST_FETCH;
          end else begin
            key_idx <= key_idx + 2'd1;
          end
        end
        ST_FETCH: state <= ST_LOAD;
        ST_LOAD: begin
          lo_hold <= res_data[7:0];
          state   <= ST_HI;
        end
        ST_HI: if (fire) state <= ST_LO;
        ST_LO: if (fire) begin
          if (res_addr == LAST_IDX) begin
            res_addr <= '0;
            if (blk_left == CNT_W'(1)) begin
              busy  <= 1'b0;
              state <= ST_HDR;
            end else begin
              blk_left <= blk_left - CNT_W'(1);
              state    <= ST_SAMP;
            end
          end else begin
            res_addr <= res_addr + ADDR_W'(1);
            state    <= ST_FETCH;
          end
        end
        default: state <= ST_HDR;
      endcase
    end
  end
endmodule

// File: rtl/xform_cmd_ctrl_chk.sv
module xform_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_ready,
  input logic       core_start,
  input logic       wr_en,
  input logic       busy
);
  // R10: receive closed during transmission
  a_r10_rx_closed: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !rx_ready);

  // R11: offered byte held until taken
  a_r11_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R4: start is a single-cycle pulse
  a_r4_start_pulse: assert property (@(posedge clk) disable iff (rst)
    core_start |=> !core_start);

  // R8: start and transmit only inside a busy window
  a_r8_start_busy: assert property (@(posedge clk) disable iff (rst)
    core_start |-> busy);
  a_r8_tx_busy: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> busy);

  // R3: a write always follows an accepted byte
  a_r3_write_after_take: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(rx_valid && rx_ready));

  // R12: idle state right after reset release
  a_r12_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rx_ready && !busy && !tx_valid));
endmodule

bind xform_cmd_ctrl xform_cmd_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
  .core_start(core_start), .wr_en(wr_en), .busy(busy)
);

// File: tb/sim_xform_cmd_ctrl.sv
module sim_xform_cmd_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic rx_valid = 1'b0, tx_ready = 1'b0, core_done = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_ready, tx_valid, core_start, core_inverse, wr_en, wr_table, busy;
  logic [7:0] tx_data, wr_data;
  logic [5:0] wr_addr, res_addr;
  logic [15:0] res_data = '0;

  xform_cmd_ctrl u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .core_start(core_start), .core_inverse(core_inverse), .core_done(core_done),
    .wr_en(wr_en), .wr_table(wr_table), .wr_addr(wr_addr), .wr_data(wr_data),
    .res_addr(res_addr), .res_data(res_data), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int blk_ctr = 0, samp_since = 0, delay = 0;
  int rx_viol = 0, start_viol = 0, busy_viol = 0, hold_viol = 0;
  bit waiting = 0, held = 0;
  logic [7:0] held_byte;
  logic [14:0] wr_log[$];
  logic [7:0]  tx_log[$];

  function automatic logic [15:0] res_val(input int b, input int i);
    return 16'(b * 32'h1357) ^ 16'(i * 32'h0203) ^ 16'h8001;
  endfunction

  // result store with one cycle read latency
  always @(posedge clk) res_data <= res_val(blk_ctr, int'(res_addr));

  // monitors, core model and transmit throttle, all away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      tx_ready = 0; core_done = 0; delay = 0; waiting = 0; held = 0; samp_since = 0;
    end else begin
      if (waiting && rx_ready) rx_viol++;
      if (tx_valid && rx_ready) rx_viol++;
      if (held && !(tx_valid && tx_data == held_byte)) hold_viol++;
      core_done = 0;
      if (wr_en) begin
        wr_log.push_back({wr_table, wr_addr, wr_data});
        if (!wr_table) samp_since++;
      end
      if (core_start) begin
        if (!busy) busy_viol++;
        if (samp_since != 64) start_viol++;
        samp_since = 0;
        blk_ctr++;
        waiting = 1;
        delay = 1 + int'($urandom % 6);
      end else if (delay > 0) begin
        delay--;
        if (delay == 0) begin core_done = 1; waiting = 0; end
      end
      if (tx_valid && !busy) busy_viol++;
      tx_ready = ($urandom % 4) != 0;
      held = tx_valid && !tx_ready;
      held_byte = tx_data;
      if (tx_valid && tx_ready) tx_log.push_back(tx_data);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    if ($urandom % 5 == 0) @(negedge clk);
    rx_valid = 1; rx_data = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic run_session(input logic [7:0] op, input int nblk);
    logic [14:0] exp_wr[$];
    logic [7:0]  exp_tx[$];
    int base, guard, bad;
    logic [7:0] v;
    base = blk_ctr; wr_log.delete(); tx_log.delete();
    send_byte(op); send_byte(8'(nblk >> 8)); send_byte(8'(nblk));
    for (int i = 0; i < 5; i++) send_byte(8'($urandom));     // R2 padding
    check(core_inverse == op[0], "R1", "core_inverse", core_inverse, op[0]);
    for (int i = 0; i < 64; i++) begin
      v = 8'($urandom); exp_wr.push_back({1'b1, 6'(i), v}); send_byte(v);
    end
    @(negedge clk);
    check(busy == (nblk != 0), "R8", "busy after table", busy, nblk != 0);
    for (int k = 0; k < nblk; k++) begin
      exp_tx.push_back(8'h64); exp_tx.push_back(8'h6F);
      exp_tx.push_back(8'h6E); exp_tx.push_back(8'h65);
      for (int i = 0; i < 64; i++) begin
        exp_tx.push_back(res_val(base + k + 1, i) >> 8);
        exp_tx.push_back(8'(res_val(base + k + 1, i)));
      end
    end
    for (int k = 0; k < nblk; k++)
      for (int i = 0; i < 64; i++) begin
        v = 8'($urandom); exp_wr.push_back({1'b0, 6'(i), v}); send_byte(v);
      end
    guard = 0;
    while (tx_log.size() < exp_tx.size() && guard < 20000) begin
      @(negedge clk); guard++;
    end
    repeat (6) @(negedge clk);
    check(wr_log.size() == exp_wr.size(), "R4", "write count", wr_log.size(), exp_wr.size());
    bad = -1;
    foreach (exp_wr[i]) if (bad < 0 && (i >= wr_log.size() || wr_log[i] != exp_wr[i])) bad = i;
    if (bad >= 0)
      check(0, exp_wr[bad][14] ? "R3" : "R4", "write entry",
            bad < wr_log.size() ? wr_log[bad] : 0, exp_wr[bad]);
    else check(1, "R3", "writes", 0, 0);
    check(tx_log.size() == exp_tx.size(), nblk == 0 ? "R9" : "R7", "tx byte count",
          tx_log.size(), exp_tx.size());
    bad = -1;
    foreach (exp_tx[i]) if (bad < 0 && (i >= tx_log.size() || tx_log[i] != exp_tx[i])) bad = i;
    if (bad >= 0)
      check(0, (bad % 132) < 4 ? "R5" : "R6", "tx byte",
            bad < tx_log.size() ? tx_log[bad] : 0, exp_tx[bad]);
    else check(1, "R6", "tx bytes", 0, 0);
    check(blk_ctr - base == nblk, "R7", "start pulses", blk_ctr - base, nblk);
    check(!busy && rx_ready, "R7", "idle after session", {busy, rx_ready}, 2'b01);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(rx_ready && !tx_valid && !busy && !core_start && !wr_en, "R12", "reset state",
          {rx_ready, tx_valid, busy, core_start, wr_en}, 5'b10000);
    run_session(8'h00, 1);
    run_session(8'h01, 3);
    run_session(8'h00, 0);   // R9
    run_session(8'hA3, 2);
    // R12: reset partway through the table
    send_byte(8'h01); send_byte(8'h00); send_byte(8'h02);
    for (int i = 0; i < 5; i++) send_byte(8'h00);
    for (int i = 0; i < 10; i++) send_byte(8'(i));
    rst = 1; repeat (2) @(negedge clk); rst = 0;
    @(negedge clk);
    check(rx_ready && !busy && !tx_valid, "R12", "state after mid reset",
          {rx_ready, busy, tx_valid}, 3'b100);
    run_session(8'h02, 1);
    check(rx_viol == 0, "R10", "rx_ready during wait or transmit", rx_viol, 0);
    check(start_viol == 0, "R4", "start before 64 samples", start_viol, 0);
    check(busy_viol == 0, "R8", "start or tx outside busy", busy_viol, 0);
    check(hold_viol == 0, "R11", "tx byte changed while stalled", hold_viol, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule